// File: doc/BRIEF.md
# Oversampling Conversion Accumulator

This block collects results from a slow analog-to-digital converter for one channel and sums a programmed number of them before telling software the set is ready. Each conversion-done strobe carries a 12-bit result. With accumulation enabled the result is added into a 15-bit running total. With accumulation disabled the result replaces the total.

A down-counter tracks how many samples are still needed. Software loads it from the sample-count field. A field value of N asks for N+1 samples. When the final sample arrives the block raises a level interrupt flag. The flag stays high until software acknowledges it.

Software clears the total before each oversampling run. A non-zero sample count makes sense only when accumulation is enabled. If the count is non-zero and accumulation is off, the flag is never raised. Averaging the total, scheduling conversions and driving the converter are left to other logic.

Top module: `sample_summer`

## Requirements
- R1: While reset is held, and on the first cycle after it, accumValue is 0, samplesLeft is 0 and irqFlag is 0.
- R2: With accumEn at 1, a taken conversion adds convResult into accumValue. The sum wraps modulo 2^15.
- R3: With accumEn at 0, a taken conversion replaces accumValue with convResult, zero-extended to 15 bits.
- R4: A clearAcc pulse sets accumValue to 0 and loads samplesLeft with sampleCount on the next cycle.
- R5: An irqAck pulse drops irqFlag and loads samplesLeft with sampleCount on the next cycle.
- R6: A taken conversion while samplesLeft is above 0 lowers samplesLeft by one and leaves irqFlag unchanged. After a reload, a count field of N therefore needs N+1 conversions before the flag is raised; a field of 3 gives 4.
- R7: A taken conversion while samplesLeft is 0 raises irqFlag when accumEn is 1 or sampleCount is 0. So with count 0 and accumEn 0, every conversion overwrites the total and raises the flag at once.
- R8: While sampleCount is non-zero and accumEn is 0, no conversion ever raises irqFlag.
- R9: A conversion is taken only when convDone is 1 and neither clearAcc nor irqAck is 1 in that same cycle. A conversion that coincides with either pulse has no effect on accumValue, samplesLeft or irqFlag beyond the effect of the pulse itself.
- R10: irqFlag is a level that holds until irqAck. Conversions taken while it is high still update accumValue, and samplesLeft stays at 0.
- R11: Eight full-scale results (4095 each) sum exactly to 32760 in accumValue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convDone | input | 1 | One-cycle strobe: a conversion result is valid |
| convResult | input | 12 | Conversion result |
| accumEn | input | 1 | 1 = add results, 0 = overwrite |
| sampleCount | input | 3 | Samples per set minus one |
| clearAcc | input | 1 | Pulse: zero the total and reload the counter |
| irqAck | input | 1 | Pulse: clear the flag and reload the counter |
| accumValue | output | 15 | Running total |
| samplesLeft | output | 3 | Conversions still needed before the flag |
| irqFlag | output | 1 | Level interrupt: the set is complete |

## Verification
Some cases are hard to reach from the ports.

- **Pulse collisions.** A conversion strobe can land in the same cycle as a clear or an acknowledge. The stimulus forces these overlaps on purpose and also lets them occur in the random phase.
- **Gated count.** A non-zero count with accumulation disabled must never raise the flag. The bench streams conversions in that state well past the point where the count would have run out.
- **Pending flag.** Conversions keep arriving while the flag is already high. The bench holds the flag and checks that the total and the counter keep following the rules.
- **Full scale.** Eight full-scale results must fill the 15-bit total exactly. The bench runs this case directly.

A behavioural model tracks all three outputs on every clock.

// File: rtl/sample_summer_pkg.sv
package sample_summer_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic zeroAcc;   // clear the total
    logic addRes;    // add the result
    logic loadRes;   // replace the total with the result
  } accStrobe_t;
endpackage

// File: rtl/sample_summer_ctrl.sv
module sample_summer_ctrl
  import sample_summer_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convDone,
  input  logic             accumEn,
  input  logic [CNT_W-1:0] sampleCount,
  input  logic             clearAcc,
  input  logic             irqAck,
  output accStrobe_t       strobe,
  output logic [CNT_W-1:0] samplesLeft,
  output logic             irqFlag
);
  logic take;
  logic lastOne;
  logic irqAllowed;

  assign take       = convDone && !clearAcc && !irqAck;
  assign lastOne    = (samplesLeft == '0);
  assign irqAllowed = accumEn || (sampleCount == '0);

  always_comb begin
    strobe.zeroAcc = clearAcc;
    strobe.addRes  = take && accumEn;
    strobe.loadRes = take && !accumEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      samplesLeft <= '0;
      irqFlag     <= 1'b0;
    end else begin
      if (clearAcc || irqAck)
        samplesLeft <= sampleCount;
      else if (take && !lastOne)
        samplesLeft <= samplesLeft - 1'b1;

      if (irqAck)
        irqFlag <= 1'b0;
      else if (take && lastOne && irqAllowed)
        irqFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/sample_summer_dp.sv
module sample_summer_dp
  import sample_summer_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int ACC_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  accStrobe_t       strobe,
  input  logic [RES_W-1:0] convResult,
  output logic [ACC_W-1:0] accumValue
);
  localparam int PAD_W = ACC_W - RES_W;

  logic [ACC_W-1:0] resWide;
  assign resWide = {{PAD_W{1'b0}}, convResult};

  always_ff @(posedge clk) begin
    if (!rstN)
      accumValue <= '0;
    else if (strobe.zeroAcc)
      accumValue <= '0;
    else if (strobe.addRes)
      accumValue <= accumValue + resWide;
    else if (strobe.loadRes)
      accumValue <= resWide;
  end
endmodule

// File: rtl/sample_summer.sv
module sample_summer
  import sample_summer_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   convDone,
  input  logic [RES_W-1:0]       convResult,
  input  logic                   accumEn,
  input  logic [CNT_W-1:0]       sampleCount,
  input  logic                   clearAcc,
  input  logic                   irqAck,
  output logic [RES_W+CNT_W-1:0] accumValue,
  output logic [CNT_W-1:0]       samplesLeft,
  output logic                   irqFlag
);
  localparam int ACC_W = RES_W + CNT_W;

  accStrobe_t strobe;

  sample_summer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .convDone(convDone), .accumEn(accumEn),
    .sampleCount(sampleCount), .clearAcc(clearAcc), .irqAck(irqAck),
    .strobe(strobe), .samplesLeft(samplesLeft), .irqFlag(irqFlag)
  );

  sample_summer_dp #(.RES_W(RES_W), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convResult(convResult),
    .accumValue(accumValue)
  );
endmodule

// File: rtl/sample_summer_chk.sv
module sample_summer_chk #(
  parameter int RES_W = 12,
  parameter int CNT_W = 3
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   convDone,
  input logic [RES_W-1:0]       convResult,
  input logic                   accumEn,
  input logic [CNT_W-1:0]       sampleCount,
  input logic                   clearAcc,
  input logic                   irqAck,
  input logic [RES_W+CNT_W-1:0] accumValue,
  input logic [CNT_W-1:0]       samplesLeft,
  input logic                   irqFlag
);
  localparam int ACC_W = RES_W + CNT_W;

  // R3
  overwrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !accumEn && !clearAcc && !irqAck) |=>
      accumValue == ACC_W'($past(convResult)));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearAcc |=> (accumValue == '0) && (samplesLeft == $past(sampleCount)));

  // R5
  ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !irqFlag && (samplesLeft == $past(sampleCount)));

  // R6
  countdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !clearAcc && !irqAck && samplesLeft != '0) |=>
      (samplesLeft == $past(samplesLeft) - 1'b1) && (irqFlag == $past(irqFlag)));

  // R8
  gated_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convDone && !accumEn && sampleCount != '0 && !irqFlag) |=> !irqFlag);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(convDone && !clearAcc && !irqAck));

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqAck) |=> irqFlag);
endmodule

bind sample_summer sample_summer_chk #(.RES_W(RES_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .convDone(convDone), .convResult(convResult),
  .accumEn(accumEn), .sampleCount(sampleCount), .clearAcc(clearAcc),
  .irqAck(irqAck), .accumValue(accumValue), .samplesLeft(samplesLeft),
  .irqFlag(irqFlag)
);

// File: tb/sample_summer_bench.sv
`timescale 1ns/1ps
module sample_summer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convDone = 1'b0;
  logic [11:0] convResult = '0;
  logic        accumEn = 1'b0;
  logic [2:0]  sampleCount = '0;
  logic        clearAcc = 1'b0;
  logic        irqAck = 1'b0;
  logic [14:0] accumValue;
  logic [2:0]  samplesLeft;
  logic        irqFlag;

  int checks = 0;
  int errors = 0;
  int mAcc = 0;
  int mLeft = 0;
  int mIrq = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  sample_summer u_sample_summer (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convResult(convResult),
    .accumEn(accumEn), .sampleCount(sampleCount), .clearAcc(clearAcc),
    .irqAck(irqAck), .accumValue(accumValue), .samplesLeft(samplesLeft),
    .irqFlag(irqFlag)
  );

  task automatic compare();
    checks += 3;
    if (int'(accumValue) != mAcc) begin
      errors++;
      $display("FAIL %s accumValue actual %0d expected %0d", tag, accumValue, mAcc);
    end
    if (int'(samplesLeft) != mLeft) begin
      errors++;
      $display("FAIL %s samplesLeft actual %0d expected %0d", tag, samplesLeft, mLeft);
    end
    if (int'(irqFlag) != mIrq) begin
      errors++;
      $display("FAIL %s irqFlag actual %0d expected %0d", tag, irqFlag, mIrq);
    end
  endtask

  // One cycle: check current outputs, drive inputs, advance the model to the next edge.
  task automatic step(input logic rst, input logic cv, input int res, input logic en,
                      input int cnt, input logic clr, input logic ack);
    @(negedge clk);
    compare();
    rstN = rst; convDone = cv; convResult = 12'(res); accumEn = en;
    sampleCount = 3'(cnt); clearAcc = clr; irqAck = ack;
    if (!rst) begin
      mAcc = 0; mLeft = 0; mIrq = 0;
    end else begin
      if (clr) begin mAcc = 0; mLeft = cnt; end
      if (ack) begin mIrq = 0; mLeft = cnt; end
      if (cv && !clr && !ack) begin
        mAcc = en ? (mAcc + res) % 32768 : res;
        if (mLeft == 0) begin
          if (en || cnt == 0) mIrq = 1;
        end else mLeft--;
      end
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 3; i++) step(0, 1, 100, 1, 3, 0, 0);
    step(1, 0, 0, 1, 3, 0, 0);

    // R4, R2, R6, R7: 4x run
    tag = "R4"; step(1, 0, 0, 1, 3, 1, 0);
    tag = "R2"; step(1, 1, 1000, 1, 3, 0, 0);
    tag = "R6"; step(1, 1, 2000, 1, 3, 0, 0);
    step(1, 0, 0, 1, 3, 0, 0);
    step(1, 1, 300, 1, 3, 0, 0);
    tag = "R7"; step(1, 1, 45, 1, 3, 0, 0);
    // R10: flag held, more conversions accumulate
    tag = "R10";
    step(1, 1, 7, 1, 3, 0, 0);
    step(1, 0, 0, 1, 3, 0, 0);
    // R5
    tag = "R5"; step(1, 0, 0, 1, 2, 0, 1);
    step(1, 0, 0, 1, 2, 0, 0);

    // R3, R7: overwrite, immediate flag with count 0
    tag = "R3"; step(1, 0, 0, 0, 0, 0, 1);
    step(1, 1, 4095, 0, 0, 0, 0);
    tag = "R7"; step(1, 1, 12, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 1);

    // R8: gated count never raises flag
    tag = "R8"; step(1, 0, 0, 0, 3, 1, 0);
    for (int i = 0; i < 12; i++) step(1, 1, 50 + i, 0, 3, 0, 0);
    step(1, 0, 0, 0, 3, 0, 0);

    // R9: conversion collides with clear and with ack
    tag = "R9"; step(1, 0, 0, 1, 1, 1, 0);
    step(1, 1, 500, 1, 1, 1, 0);
    step(1, 1, 600, 1, 1, 0, 0);
    step(1, 1, 700, 1, 1, 0, 0);
    step(1, 1, 800, 1, 1, 0, 1);
    step(1, 0, 0, 1, 1, 0, 0);

    // R11: eight full-scale samples
    tag = "R11"; step(1, 0, 0, 1, 7, 1, 1);
    for (int i = 0; i < 8; i++) step(1, 1, 4095, 1, 7, 0, 0);
    step(1, 0, 0, 1, 7, 0, 0);
    step(1, 0, 0, 1, 7, 0, 0);

    // R2: random traffic including wrap and collisions
    tag = "R2";
    for (int i = 0; i < 400; i++)
      step(1, 1'($urandom_range(0, 1)), int'($urandom_range(0, 4095)),
           1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
           1'($urandom_range(0, 15) == 0), 1'($urandom_range(0, 7) == 0));
    step(1, 0, 0, 1, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule